// File: doc/BRIEF.md
# Two-Pass Impulse Noise Filter Sequencer

The block cleans impulse ("salt and pepper") noise out of an 8-bit greyscale image held in an external single-port SRAM. The SRAM holds two image-sized regions. Region A, at word addresses `0 .. W*H-1`, holds the source image and later the final result. Region B, at `W*H .. 2*W*H-1`, is the buffer between the two passes. A pixel at row `r` and column `c` sits at offset `r*W + c` inside either region.

A host loads the source image while it holds the control input `ld_active` high, then lowers it. That falling edge starts the sequencer. The horizontal pass reads each row of region A and writes the filtered row into region B. The vertical pass then reads each column of region B and writes the filtered column back into region A.

Each output pixel comes from a three-tap window along the current scan direction. The window median replaces the centre pixel only when the centre lies further than a programmable threshold from that median. When a line ends, the missing neighbour is mirrored from the pixel next to the edge. A one-cycle `done` pulse marks the end of the job.

Top module: `despeckle_seq`

## Requirements
- R1: After reset, and whenever the block is idle, a rising edge on `ld_active` starts nothing: `mem_req` stays low. Only a falling edge (1 then 0 on consecutive clocks) of `ld_active` while idle starts a job.
- R2: After reset the block is idle, with `mem_req`, `mem_we` and `done` all low.
- R3: The horizontal pass handles rows top to bottom and, within a row, columns left to right. It reads region A (address `r*W+c`) and writes region B (address `W*H + r*W + c`). Its writes appear in that same row-major order.
- R4: The vertical pass handles columns left to right and, within a column, rows top to bottom. It reads region B and writes region A at address `r*W+c`, with its writes in that column-major order.
- R5: At the first pixel of a line, both neighbours take the value of the second pixel. At the last pixel, both take the value of the next-to-last pixel.
- R6: With centre `m`, neighbours `a` and `b`, and median `med` of the three, the output is `med` when `|m - med| > thr`, and `m` otherwise. The comparison is strict, so `thr = 255` leaves every pixel unchanged.
- R7: Memory access is one request at a time. `mem_req` stays high with a stable `mem_addr` and `mem_we` until `mem_ack`. Write data is valid while `mem_we` is high, and read data is taken in the cycle `mem_ack` is high.
- R8: `done` is high for exactly one cycle, the cycle after the acknowledge of the last vertical-pass write, and no request is pending during it.
- R9: Edges on `ld_active` while a job is running are ignored: the job completes with exactly `2*W*H` writes and does not restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_active | input | 1 | High while the image is being loaded; falling edge starts a job |
| thr | input | 8 | Noise decision threshold |
| mem_req | output | 1 | Memory request pending |
| mem_we | output | 1 | Request is a write (1) or a read (0) |
| mem_addr | output | clog2(2*W*H) | Word address of the request |
| mem_wdata | output | 8 | Write data |
| mem_ack | input | 1 | One-cycle acknowledge of the pending request |
| mem_rdata | input | 8 | Read data, valid with `mem_ack` |
| done | output | 1 | One-cycle end-of-job pulse |

## Verification
The assertions check on every cycle the properties that local state can decide:
- the handshake holds address and direction steady until acknowledge;
- each pass reads from and writes to its own SRAM region;
- `done` is a lone pulse with the bus quiet;
- an idle rising edge of `ld_active` raises no request.

The bench's scenarios are needed for the rest:
- the exact order of the writes;
- the pixel values, including mirrored borders and the strict threshold boundary;
- the count of writes before `done`;
- the immunity to control edges during a job.

The bench compares both SRAM regions against an image model filtered arithmetically, row pass then column pass.

// File: rtl/despeckle_pkg.sv
package despeckle_pkg;

    typedef logic [7:0] pix_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD,
        ST_WR,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        pix_t lft;
        pix_t ctr;
        pix_t rgt;
    } win3_t;

    function automatic pix_t med3(input pix_t a, input pix_t b, input pix_t c);
        pix_t lo;
        pix_t hi;
        pix_t mid;
        lo  = (a < b) ? a : b;
        hi  = (a < b) ? b : a;
        mid = (hi < c) ? hi : c;
        return (lo > mid) ? lo : mid;
    endfunction

    function automatic pix_t absdiff(input pix_t a, input pix_t b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

    function automatic pix_t soft_median(input win3_t w, input pix_t thr);
        pix_t med;
        med = med3(w.lft, w.ctr, w.rgt);
        return (absdiff(w.ctr, med) > thr) ? med : w.ctr;
    endfunction

endpackage

// File: rtl/despeckle_start.sv
module despeckle_start (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic ctl,
    output logic go
);
    logic ctl_q;

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= 1'b0;
        else     ctl_q <= ctl;
    end

    // falling edge only, and only while armed
    assign go = arm && ctl_q && !ctl;
endmodule

// File: rtl/despeckle_window.sv
module despeckle_window
    import despeckle_pkg::*;
#(
    parameter int TAPS = 3
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  shift,
    input  pix_t  din,
    input  logic  first,
    input  logic  last,
    output win3_t win
);
    pix_t tap [TAPS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TAPS; i++) tap[i] <= '0;
        end else if (shift) begin
            for (int i = 0; i < TAPS - 1; i++) tap[i] <= tap[i + 1];
            tap[TAPS - 1] <= din;
        end
    end

    // mirror the missing neighbour at either end of a line
    always_comb begin
        if (last) begin
            win.lft = tap[TAPS - 2];
            win.ctr = tap[TAPS - 1];
            win.rgt = tap[TAPS - 2];
        end else begin
            win.lft = first ? tap[TAPS - 1] : tap[0];
            win.ctr = tap[TAPS - 2];
            win.rgt = tap[TAPS - 1];
        end
    end
endmodule

// File: rtl/despeckle_kernel.sv
module despeckle_kernel
    import despeckle_pkg::*;
(
    input  win3_t win,
    input  pix_t  thr,
    output pix_t  q
);
    assign q = soft_median(win, thr);
endmodule

// File: rtl/despeckle_seq.sv
module despeckle_seq
    import despeckle_pkg::*;
#(
    parameter int IMG_W = 6,
    parameter int IMG_H = 4,
    localparam int NPIX   = IMG_W * IMG_H,
    localparam int ADDR_W = $clog2(2 * NPIX)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_active,
    input  logic [7:0]        thr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ack,
    input  logic [7:0]        mem_rdata,
    output logic              done
);
    localparam int MAXD = (IMG_W > IMG_H) ? IMG_W : IMG_H;
    localparam int CW   = $clog2(MAXD + 1);
    localparam logic [ADDR_W-1:0] REGION_B = ADDR_W'(NPIX);

    seq_state_e    state;
    logic          pass_q;      // 0: rows, 1: columns
    logic [CW-1:0] line_q;
    logic [CW-1:0] rd_idx;
    logic [CW-1:0] wr_idx;
    logic [CW-1:0] line_len;
    logic [CW-1:0] line_cnt;
    logic [CW-1:0] cur_idx;
    logic [CW-1:0] row;
    logic [CW-1:0] col;
    logic          go;
    win3_t         win;
    pix_t          filt;

    despeckle_start u_start (
        .clk (clk),
        .rst (rst),
        .arm (state == ST_IDLE),
        .ctl (ld_active),
        .go  (go)
    );

    despeckle_window #(.TAPS(3)) u_win (
        .clk   (clk),
        .rst   (rst),
        .shift (state == ST_RD && mem_ack),
        .din   (mem_rdata),
        .first (wr_idx == '0),
        .last  (wr_idx == line_len - 1'b1),
        .win   (win)
    );

    despeckle_kernel u_kern (
        .win (win),
        .thr (thr),
        .q   (filt)
    );

    assign line_len = pass_q ? CW'(IMG_H) : CW'(IMG_W);
    assign line_cnt = pass_q ? CW'(IMG_W) : CW'(IMG_H);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            pass_q <= 1'b0;
            line_q <= '0;
            rd_idx <= '0;
            wr_idx <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (go) begin
                        state  <= ST_RD;
                        pass_q <= 1'b0;
                        line_q <= '0;
                        rd_idx <= '0;
                        wr_idx <= '0;
                    end
                end
                ST_RD: begin
                    if (mem_ack) begin
                        rd_idx <= rd_idx + 1'b1;
                        if (rd_idx != '0) state <= ST_WR;
                    end
                end
                ST_WR: begin
                    if (mem_ack) begin
                        if (wr_idx == line_len - 1'b1) begin
                            rd_idx <= '0;
                            wr_idx <= '0;
                            if (line_q == line_cnt - 1'b1) begin
                                line_q <= '0;
                                if (pass_q) begin
                                    state <= ST_DONE;
                                end else begin
                                    pass_q <= 1'b1;
                                    state  <= ST_RD;
                                end
                            end else begin
                                line_q <= line_q + 1'b1;
                                state  <= ST_RD;
                            end
                        end else begin
                            wr_idx <= wr_idx + 1'b1;
                            if (rd_idx != line_len) state <= ST_RD;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign cur_idx = (state == ST_WR) ? wr_idx : rd_idx;
    assign row     = pass_q ? cur_idx : line_q;
    assign col     = pass_q ? line_q : cur_idx;

    assign mem_req   = (state == ST_RD) || (state == ST_WR);
    assign mem_we    = (state == ST_WR);
    assign mem_addr  = ADDR_W'(row) * ADDR_W'(IMG_W) + ADDR_W'(col)
                     + ((mem_we ^ pass_q) ? REGION_B : '0);
    assign mem_wdata = filt;
    assign done      = (state == ST_DONE);

endmodule

// File: rtl/despeckle_checker.sv
module despeckle_checker #(
    parameter int NPIX   = 24,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              ld_active,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic              done,
    input logic              pass_q
);
    localparam logic [ADDR_W-1:0] REGION_B = ADDR_W'(NPIX);

    AST_RISE_NO_START: assert property (@(posedge clk) disable iff (rst)
        (!mem_req && !done && $rose(ld_active)) |=> !mem_req); // R1

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R7

    AST_ROW_READ_SRC: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && !pass_q) |-> (mem_addr < REGION_B)); // R3

    AST_ROW_WRITE_BUF: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && !pass_q) |-> (mem_addr >= REGION_B)); // R3

    AST_COL_REGIONS: assert property (@(posedge clk) disable iff (rst)
        (mem_req && pass_q) |-> (mem_we ? (mem_addr < REGION_B) : (mem_addr >= REGION_B))); // R4

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_req); // R8
endmodule

bind despeckle_seq despeckle_checker #(.NPIX(NPIX), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ld_active (ld_active),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .done      (done),
    .pass_q    (pass_q)
);

// File: tb/test_despeckle_seq.sv
module test_despeckle_seq;
    localparam int W  = 5;
    localparam int H  = 3;
    localparam int N  = W * H;
    localparam int AW = $clog2(2 * N);

    logic          clk = 1'b0;
    logic          rst;
    logic          ld_active;
    logic [7:0]    thr;
    logic          mem_req;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic          mem_ack;
    logic [7:0]    mem_rdata;
    logic          done;

    always #4 clk = ~clk;   // 125 MHz

    despeckle_seq #(.IMG_W(W), .IMG_H(H)) i_despeckle_seq (
        .clk       (clk),
        .rst       (rst),
        .ld_active (ld_active),
        .thr       (thr),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .done      (done)
    );

    int n_checks = 0;
    int n_errors = 0;

    logic [7:0] mem [2*N];
    int src [N];
    int mid [N];
    int fin [N];
    logic do_load;

    int wr_count;
    int ord_bad3;
    int ord_bad4;
    int done_seen;
    int done_bad;

    // SRAM model: one acknowledge per request, one cycle after acceptance
    always @(posedge clk) begin
        if (rst) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
        end else if (do_load) begin
            for (int i = 0; i < N; i++) begin
                mem[i]     <= 8'(src[i]);
                mem[N + i] <= 8'hAA;
            end
            wr_count  = 0;
            ord_bad3  = 0;
            ord_bad4  = 0;
            done_seen = 0;
            done_bad  = 0;
        end else begin
            if (mem_ack) begin
                mem_ack <= 1'b0;
            end else if (mem_req) begin
                mem_ack <= 1'b1;
                if (mem_we) begin
                    mem[mem_addr] <= mem_wdata;
                    if (wr_count < N) begin
                        if (int'(mem_addr) != N + wr_count) ord_bad3++;
                    end else begin
                        if (int'(mem_addr) != ((wr_count - N) % H) * W + (wr_count - N) / H)
                            ord_bad4++;
                    end
                    wr_count++;
                end else begin
                    mem_rdata <= mem[mem_addr];
                end
            end
            if (done) begin
                done_seen++;
                if (wr_count != 2 * N) done_bad++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int kern(input int a, input int m, input int b, input int t);
        int med;
        int d;
        med = (a + m + b) - ((a > m ? a : m) > b ? (a > m ? a : m) : b)
                          - ((a < m ? a : m) < b ? (a < m ? a : m) : b);
        d = (m > med) ? m - med : med - m;
        return (d > t) ? med : m;
    endfunction

    function automatic int pattern(input int mode, input int r, input int c);
        if (mode == 9) return (r == 1 && c == 2) ? 140 : 100;
        if ((r * 3 + c + mode) % 5 == 2) return 255;
        if ((r + 2 * c + mode) % 7 == 3) return 0;
        return (r * 37 + c * 53 + mode * 11) % 256;
    endfunction

    task automatic build_golden(input int mode, input int t);
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++)
                src[r*W + c] = pattern(mode, r, c);
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++) begin
                int l;
                int rt;
                l  = (c == 0)     ? src[r*W + 1]     : src[r*W + c - 1];
                rt = (c == W - 1) ? src[r*W + W - 2] : src[r*W + c + 1];
                if (c == 0) rt = src[r*W + 1];
                mid[r*W + c] = kern(l, src[r*W + c], rt, t);
            end
        for (int c = 0; c < W; c++)
            for (int r = 0; r < H; r++) begin
                int u;
                int d;
                u = (r == 0)     ? mid[W + c]         : mid[(r-1)*W + c];
                d = (r == H - 1) ? mid[(H-2)*W + c]   : mid[(r+1)*W + c];
                if (r == 0) d = mid[W + c];
                fin[r*W + c] = kern(u, mid[r*W + c], d, t);
            end
    endtask

    task automatic run_case(input int mode, input int t, input bit poke);
        int waited;
        build_golden(mode, t);
        @(negedge clk);
        thr     = 8'(t);
        do_load = 1'b1;
        @(negedge clk);
        do_load   = 1'b0;
        ld_active = 1'b1;
        repeat (3) @(negedge clk);
        ld_active = 1'b0;   // falling edge starts the job
        waited = 0;
        while (done_seen == 0 && waited < 4000) begin
            @(negedge clk);
            waited++;
            if (poke && waited == 20) ld_active = 1'b1;
            if (poke && waited == 22) ld_active = 1'b0;
        end
        repeat (2) @(negedge clk);
        chk(done_seen == 1, "R8 done pulse count", done_seen, 1);
        chk(done_bad == 0, "R8 done after last write", done_bad, 0);
        chk(ord_bad3 == 0, "R3 row-pass write order", ord_bad3, 0);
        chk(ord_bad4 == 0, "R4 column-pass write order", ord_bad4, 0);
        chk(wr_count == 2 * N, poke ? "R9 write count with busy edges" : "R4 write count",
            wr_count, 2 * N);
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++) begin
                int i;
                i = r * W + c;
                chk(int'(mem[N + i]) == mid[i],
                    (c == 0 || c == W - 1) ? "R5 row-pass border pixel" : "R6 row-pass pixel",
                    int'(mem[N + i]), mid[i]);
                chk(int'(mem[i]) == fin[i],
                    (r == 0 || r == H - 1) ? "R5 column-pass border pixel" : "R6 final pixel",
                    int'(mem[i]), fin[i]);
                if (t == 255)
                    chk(int'(mem[i]) == src[i], "R6 max threshold identity", int'(mem[i]), src[i]);
            end
        repeat (20) begin
            @(negedge clk);
            chk(!mem_req, poke ? "R9 no restart after job" : "R1 stays idle", int'(mem_req), 0);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        rst       = 1'b1;
        ld_active = 1'b0;
        thr       = '0;
        do_load   = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!mem_req, "R2 reset request low", int'(mem_req), 0);
        chk(!mem_we,  "R2 reset write low",   int'(mem_we), 0);
        chk(!done,    "R2 reset done low",    int'(done), 0);
        ld_active = 1'b1;   // rising edge only
        repeat (10) begin
            @(negedge clk);
            chk(!mem_req, "R1 rise does not start", int'(mem_req), 0);
        end
        run_case(0, 0, 1'b0);
        run_case(1, 30, 1'b0);
        run_case(2, 255, 1'b0);
        run_case(9, 40, 1'b0);   // diff equals thr: kept
        run_case(9, 39, 1'b1);   // diff exceeds thr: replaced, edges while busy
        run_case(3, 10, 1'b0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule